// File: doc/BRIEF.md
# DRAM Refresh Interval Scheduler

This block decides when a DRAM must be refreshed and keeps host traffic out of the way while it is. A free-running tick counter divides the system clock down to the refresh interval. In the distributed policy, each tick owes one refresh cycle. In the burst policy, the ticks are only counted; once a full retention period has passed (row count × interval), the block owes one refresh per row. It issues these back to back and lets no host command through until the last one completes.

The block never cuts an access short. When refresh is owed, it deasserts the host ready signal. It then waits until the sequencer reports no access in flight, and until the cycle after the last host acceptance has passed. Only then does it pulse a one-cycle refresh strobe. The sequencer answers each strobe with a one-cycle done pulse. Only one refresh is outstanding at a time. If the sequencer stays busy longer than one interval, the owed refreshes are counted up to a small cap and issued back to back once it is free.

The refresh policy, the interval class (standard or extended, about eight times longer) and the row count are configuration inputs. They are taken only while reset is high.

Top module: `refresh_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, `host_ready` is 1 and `rf_stb` is 0.
- R2: With the distributed policy and the standard interval, strobes on an idle sequencer are spaced exactly `STD_CLKS` cycles apart.
- R3: With the distributed policy and the extended interval (`cfg_extended`=1), strobes are spaced exactly `EXT_CLKS` cycles apart.
- R4: With the burst policy (`cfg_burst`=1), each burst issues exactly `cfg_rows` strobes. Each strobe follows the done pulse of the one before it.
- R5: With the burst policy, consecutive bursts start exactly `cfg_rows` × interval cycles apart.
- R6: `rf_stb` is never 1 in the cycle after `seq_busy` was 1, nor two cycles after a host acceptance (`host_valid` and `host_ready` both 1).
- R7: While refresh is owed and the last owed done has not arrived, `host_ready` is 0 from the next cycle on. It is 0 at every strobe, including all strobes of a burst.
- R8: Refreshes owed while the sequencer is busy accumulate. After release, all of them are issued back to back (two intervals of stall give two strobes).
- R9: The owed count saturates at `PEND_MAX`. A stall of five intervals with `PEND_MAX`=3 yields exactly three strobes.
- R10: After a strobe, no further strobe is issued until `rf_done` has been seen.
- R11: Changes to `cfg_burst`, `cfg_extended` and `cfg_rows` while reset is low have no effect on the strobe pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| cfg_burst | input | 1 | 1 = burst policy, 0 = distributed policy |
| cfg_extended | input | 1 | 1 = extended interval (`EXT_CLKS`), 0 = standard (`STD_CLKS`) |
| cfg_rows | input | ROW_W | Rows per retention period (0 is treated as 1) |
| host_valid | input | 1 | Host presents an access request |
| host_ready | output | 1 | Host may start an access this cycle (registered) |
| seq_busy | input | 1 | Sequencer is executing a host access |
| rf_stb | output | 1 | One-cycle refresh command to the sequencer (registered) |
| rf_done | input | 1 | One-cycle pulse from the sequencer when a refresh cycle completes |

## Verification
On every cycle, the embedded assertions check four things: the strobe never follows a busy sequencer or a fresh host acceptance, a second strobe never overtakes an outstanding refresh, owed refresh drops host ready, and the owed count and tick counter stay in range. Exact spacing is visible only in the bench scenarios: standard interval, extended interval, burst length and burst period, across several configurations. The same holds for the number of strobes released after a long stall, saturation at the cap, and configuration inputs being ignored outside reset.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_DRAIN = 2'd1,
    RS_WAIT  = 2'd2
  } rs_state_e;
endpackage

// File: rtl/rs_tick_gen.sv
module rs_tick_gen #(
  parameter int STD_CLKS = 1950,
  parameter int EXT_CLKS = 15625
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_extended,
  output logic tick
);
  localparam int CNT_W = $clog2(EXT_CLKS + 1);
  localparam logic [CNT_W-1:0] STD_LIM = CNT_W'(STD_CLKS - 1);
  localparam logic [CNT_W-1:0] EXT_LIM = CNT_W'(EXT_CLKS - 1);

  logic             ext_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = ext_q ? EXT_LIM : STD_LIM;
  assign tick  = !rst && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= cfg_extended;
      cnt   <= '0;
    end else if (cnt == limit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2/R3: the divider never runs past the selected interval
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= limit);
endmodule

// File: rtl/rs_debt.sv
module rs_debt #(
  parameter int ROW_W    = 12,
  parameter int PEND_MAX = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_burst,
  input  logic [ROW_W-1:0] cfg_rows,
  input  logic             tick,
  input  logic             done,
  output logic             owe,
  output logic             more
);
  localparam int PEND_W = $clog2(PEND_MAX + 1);
  localparam logic [PEND_W-1:0] PEND_CAP = PEND_W'(PEND_MAX);
  localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);
  localparam logic [ROW_W-1:0]  ROW_ONE  = ROW_W'(1);

  logic             burst_q;
  logic [ROW_W-1:0] rows_q;
  logic [ROW_W-1:0] slot;
  logic [ROW_W-1:0] brem;
  logic [PEND_W-1:0] pend;
  logic             period_end;

  assign period_end = tick && (slot == rows_q - ROW_ONE);
  assign owe  = (pend != '0) || (brem != '0);
  assign more = (pend > PEND_ONE) || (brem > ROW_ONE) ||
                ((pend != '0) && (brem != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_q <= cfg_burst;
      rows_q  <= (cfg_rows == '0) ? ROW_ONE : cfg_rows;
      slot    <= '0;
      brem    <= '0;
      pend    <= '0;
    end else if (burst_q) begin
      if (tick) slot <= period_end ? '0 : slot + ROW_ONE;
      if (period_end)              brem <= rows_q;
      else if (done && brem != '0) brem <= brem - ROW_ONE;
    end else begin
      case ({tick, done && (pend != '0)})
        2'b10:   if (pend != PEND_CAP) pend <= pend + PEND_ONE;
        2'b01:   pend <= pend - PEND_ONE;
        default: pend <= pend;
      endcase
    end
  end

  assert_pend_cap_R9: assert property (@(posedge clk) disable iff (rst)
    pend <= PEND_CAP);
  assert_burst_bound_R4: assert property (@(posedge clk) disable iff (rst)
    brem <= rows_q);
endmodule

// File: rtl/rs_arbiter.sv
module rs_arbiter
  import refresh_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic owe,
  input  logic more,
  input  logic seq_busy,
  input  logic host_fire,
  input  logic rf_done,
  output logic rf_stb,
  output logic host_ready
);
  rs_state_e state, state_d;
  logic      grant_q;
  logic      issue;

  assign issue = (state == RS_DRAIN) && !seq_busy && !grant_q;

  always_comb begin
    state_d = state;
    case (state)
      RS_IDLE:  if (owe)     state_d = RS_DRAIN;
      RS_DRAIN: if (issue)   state_d = RS_WAIT;
      RS_WAIT:  if (rf_done) state_d = more ? RS_DRAIN : RS_IDLE;
      default:               state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RS_IDLE;
      grant_q    <= 1'b0;
      rf_stb     <= 1'b0;
      host_ready <= 1'b1;
    end else begin
      state      <= state_d;
      grant_q    <= host_fire;
      rf_stb     <= issue;
      host_ready <= (state_d == RS_IDLE);
    end
  end

  assert_no_stb_busy_R6: assert property (@(posedge clk) disable iff (rst)
    rf_stb |-> !$past(seq_busy));
  assert_no_stb_grant_R6: assert property (@(posedge clk) disable iff (rst)
    rf_stb |-> !$past(host_fire, 2));
  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (rst)
    (state == RS_WAIT && !rf_done) |=> !rf_stb);
  assert_ready_low_R7: assert property (@(posedge clk) disable iff (rst)
    (owe && !rf_done) |=> !host_ready);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int STD_CLKS = 1950,
  parameter int EXT_CLKS = 15625,
  parameter int ROW_W    = 12,
  parameter int PEND_MAX = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_burst,
  input  logic             cfg_extended,
  input  logic [ROW_W-1:0] cfg_rows,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic             seq_busy,
  output logic             rf_stb,
  input  logic             rf_done
);
  logic tick, owe, more, host_fire;

  assign host_fire = host_valid && host_ready;

  rs_tick_gen #(.STD_CLKS(STD_CLKS), .EXT_CLKS(EXT_CLKS)) u_tick (
    .clk(clk), .rst(rst), .cfg_extended(cfg_extended), .tick(tick)
  );

  rs_debt #(.ROW_W(ROW_W), .PEND_MAX(PEND_MAX)) u_debt (
    .clk(clk), .rst(rst), .cfg_burst(cfg_burst), .cfg_rows(cfg_rows),
    .tick(tick), .done(rf_done), .owe(owe), .more(more)
  );

  rs_arbiter u_arb (
    .clk(clk), .rst(rst), .owe(owe), .more(more), .seq_busy(seq_busy),
    .host_fire(host_fire), .rf_done(rf_done), .rf_stb(rf_stb),
    .host_ready(host_ready)
  );
endmodule

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;
  localparam int STD = 20;
  localparam int EXT = 160;
  localparam int RW  = 8;
  localparam int PMAX = 3;

  typedef struct packed {
    logic        burst;
    logic        ext;
    logic [7:0]  rows;
    logic [15:0] len;
    logic [15:0] period;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd4, 16'd1, 16'd20},
    '{1'b0, 1'b1, 8'd4, 16'd1, 16'd160},
    '{1'b1, 1'b0, 8'd4, 16'd4, 16'd80},
    '{1'b1, 1'b0, 8'd2, 16'd2, 16'd40},
    '{1'b1, 1'b1, 8'd3, 16'd3, 16'd480}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_burst = 1'b0, cfg_extended = 1'b0;
  logic [RW-1:0] cfg_rows = 8'd4;
  logic host_valid = 1'b0, seq_busy = 1'b0, rf_done = 1'b0;
  logic host_ready, rf_stb;

  int checks = 0, fails = 0, cyc = 0;
  int last_t = -1000, run_len = 0, prev_len = 0, bstart = 0, prev_bstart = 0, runs = 0;
  int nstb = 0, bad_ready = 0, bad_busy = 0, bad_out = 0;
  logic outstanding = 1'b0, prev_busy = 1'b0;

  always #4 clk = ~clk;

  refresh_sched #(.STD_CLKS(STD), .EXT_CLKS(EXT), .ROW_W(RW), .PEND_MAX(PMAX)) u_refresh_sched (
    .clk(clk), .rst(rst), .cfg_burst(cfg_burst), .cfg_extended(cfg_extended),
    .cfg_rows(cfg_rows), .host_valid(host_valid), .host_ready(host_ready),
    .seq_busy(seq_busy), .rf_stb(rf_stb), .rf_done(rf_done)
  );

  initial forever begin
    @(posedge clk);
    if (rst) cyc = 0; else cyc = cyc + 1;
  end

  // monitor and sequencer model, both away from the rising edge
  initial forever begin
    @(negedge clk);
    if (rst) begin
      last_t = -1000; run_len = 0; prev_len = 0; runs = 0;
      outstanding = 1'b0; rf_done = 1'b0;
    end else begin
      if (rf_done) begin rf_done = 1'b0; outstanding = 1'b0; end
      else if (outstanding) rf_done = 1'b1;
      if (rf_stb) begin
        nstb = nstb + 1;
        if (host_ready) bad_ready = bad_ready + 1;
        if (prev_busy) bad_busy = bad_busy + 1;
        if (outstanding) bad_out = bad_out + 1;
        outstanding = 1'b1;
        if (cyc - last_t > 10) begin
          runs = runs + 1; prev_len = run_len; prev_bstart = bstart;
          bstart = cyc; run_len = 1;
        end else run_len = run_len + 1;
        last_t = cyc;
      end
    end
    prev_busy = seq_busy;
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic b, input logic e, input logic [RW-1:0] r);
    rst = 1'b1; cfg_burst = b; cfg_extended = e; cfg_rows = r;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    do begin @(posedge clk); #1; end while (cyc < n);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n0;
    // R1: reset state
    do_reset(1'b0, 1'b0, 8'd4);
    @(negedge clk);
    check("R1 ready", int'(host_ready), 1);
    check("R1 stb", int'(rf_stb), 0);

    // R2 R3 R4 R5: table walk
    for (int i = 0; i < NV; i++) begin
      do_reset(VECS[i].burst, VECS[i].ext, VECS[i].rows);
      while (runs < 2 && cyc < 3000) begin @(posedge clk); #1; end
      check(VECS[i].burst ? "R4 burst length" : "R2/R3 single strobe",
            prev_len, int'(VECS[i].len));
      check(VECS[i].burst ? "R5 burst period" : (VECS[i].ext ? "R3 spacing" : "R2 spacing"),
            bstart - prev_bstart, int'(VECS[i].period));
    end

    // R11: config changes after reset are ignored
    do_reset(1'b0, 1'b0, 8'd4);
    cfg_burst = 1'b1; cfg_extended = 1'b1; cfg_rows = 8'd7;
    while (runs < 2 && cyc < 3000) begin @(posedge clk); #1; end
    check("R11 spacing", bstart - prev_bstart, STD);
    check("R11 length", prev_len, 1);

    // R6 with host traffic: spacing kept, grant cycle respected
    do_reset(1'b0, 1'b0, 8'd4);
    host_valid = 1'b1;
    while (runs < 2 && cyc < 3000) begin @(posedge clk); #1; end
    check("R6 spacing with host traffic", bstart - prev_bstart, STD);
    host_valid = 1'b0;

    // R8: two intervals of stall
    do_reset(1'b0, 1'b0, 8'd4);
    wait_cyc(2); seq_busy = 1'b1;
    n0 = nstb;
    wait_cyc(2 * STD + 1);
    check("R6 no strobe while busy", nstb - n0, 0);
    check("R7 ready low while owed", int'(host_ready), 0);
    seq_busy = 1'b0;
    do begin @(negedge clk); end while (!host_ready && cyc < 2 * STD + 30);
    check("R8 strobes after stall", nstb - n0, 2);

    // R9: five intervals of stall saturate at PEND_MAX
    do_reset(1'b0, 1'b0, 8'd4);
    wait_cyc(2); seq_busy = 1'b1;
    n0 = nstb;
    wait_cyc(5 * STD + 1);
    seq_busy = 1'b0;
    do begin @(negedge clk); end while (!host_ready && cyc < 5 * STD + 30);
    check("R9 saturated strobes", nstb - n0, PMAX);

    check("R7 ready at strobes", bad_ready, 0);
    check("R6 strobe after busy", bad_busy, 0);
    check("R10 overlapping strobes", bad_out, 0);
    finish_run();
  end
endmodule